// File: doc/BRIEF.md
# Core Test Wrapper Serial Controller

This block wraps the functional pins of an embedded core so that the core and its surroundings can be tested through a single serial path. There is no controlling state machine. An external test controller drives a small group of enable lines directly, and each enabled operation happens on the next rising edge of the test clock. The block holds three registers. A 3-bit instruction register chooses the operating mode. A 1-bit bypass register shortens the serial path. A boundary register of `NUM_CELLS` cells sits between the core pins and the logic around them.

Each boundary cell has three storage bits:
- a shift bit, which lies on the serial path;
- a hold bit, which receives captured pin values;
- an update bit, which drives test data onto the pin when the mode asks for it.

A transfer moves the hold bit into the shift bit. A snapshot of the pins can therefore be taken while a shift pattern is still in the chain, and it reaches the serial path only when a transfer is requested.

Each cell's position is set by a parameter. A core-input cell sits between a chip-level net and a core input. A core-output cell sits between a core output and a chip-level net. The instruction selects one of four cell modes:
- **normal**: every cell passes its functional input through.
- **inward**: core-input cells drive their update bit into the core.
- **outward**: core-output cells drive their update bit onto the surrounding nets.
- **safe**: every cell drives a fixed per-cell value.

Mode changes happen only on the instruction update transition.

Top module: `core_wrap_ctrl`

## Requirements
- R1: After `trst_n` is low, the instruction is bypass (code 000). In that mode `func_out` equals `func_in`, the bypass bit reads 0, and the instruction shift stage is 000.
- R2: While `sel_instr` is high, `shf_en` shifts the 3-bit instruction stage one place toward `ser_out`. Bits enter at bit 2 and leave from bit 0, so a code is loaded LSB first. The active instruction changes only on a cycle with `upd_en` and `sel_instr` both high. Codes: 000 bypass, 001 external test, 010 preload, 011 internal test, 100 clamp, 101 safe; 110 and 111 act as bypass.
- R3: A capture with `sel_instr` high loads the instruction shift stage with 001. Shifting it out then gives 1, 0, 0 on `ser_out`.
- R4: Codes 000, 100, 101, 110 and 111 place the 1-bit bypass register between `ser_in` and `ser_out`. In that register a shift delays `ser_in` by one cycle, and a capture loads 0.
- R5: Codes 001, 010 and 011 place the boundary register on the serial path, cell 0 nearest `ser_out`. After `NUM_CELLS` shifts, the bit fed in cycle k sits in cell k, and the old content of cell k appears on `ser_out` in cycle k.
- R6: A capture copies `func_in` into each cell's hold bit and leaves the shift bits unchanged.
- R7: A transfer copies each hold bit into its shift bit.
- R8: An update with `sel_instr` low copies the shift bits into the update bits when the boundary register is selected. The outputs change only then.
- R9: Codes 000, 010, 110 and 111 give normal mode: `func_out` equals `func_in`.
- R10: Codes 001 and 100 give outward mode. In this mode core-output cells (mask bit 0) drive their update bit and core-input cells pass `func_in`.
- R11: Code 011 gives inward mode. In this mode core-input cells (mask bit 1) drive their update bit and core-output cells pass `func_in`.
- R12: Code 101 forces every `func_out` bit to its `SAFE_VALUE` bit, whatever `func_in` is.
- R13: When several boundary enables are high together, shift beats capture and capture beats transfer. Only the winning operation happens.
- R14: While the bypass register is selected, boundary shift, capture and update have no effect on the cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tclk | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low wrapper reset |
| ser_in | input | 1 | Serial test data in |
| sel_instr | input | 1 | High: instruction register on the serial path; low: the selected data register |
| cap_en | input | 1 | Capture enable |
| shf_en | input | 1 | Shift enable |
| upd_en | input | 1 | Update enable |
| xfer_en | input | 1 | Transfer enable (hold bit to shift bit) |
| func_in | input | NUM_CELLS | Functional values arriving at each cell |
| func_out | output | NUM_CELLS | Functional values leaving each cell |
| ser_out | output | 1 | Serial test data out |

## Verification
Two collisions are provoked. The first raises shift and capture in the same cycle. The test then transfers the hold bits and shifts them out, and the result must be the value captured earlier, not the pin value present during the collision. The second raises capture and transfer together over a known shift pattern. The shift-out must return that pattern unchanged, and a later transfer must expose the newly captured pin value. Every instruction code is swept against all `func_in` values, with the expected output worked out from the mode mask arithmetic.

// File: rtl/wcw_pkg.sv
package wcw_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_BYPASS  = 3'b000,
        OP_EXTEST  = 3'b001,
        OP_PRELOAD = 3'b010,
        OP_INTEST  = 3'b011,
        OP_CLAMP   = 3'b100,
        OP_SAFE    = 3'b101,
        OP_RSVD6   = 3'b110,
        OP_RSVD7   = 3'b111
    } wcw_op_e;

    typedef enum logic [1:0] {
        MODE_NORMAL,
        MODE_INWARD,
        MODE_OUTWARD,
        MODE_SAFE
    } wcw_mode_e;

    localparam logic [OP_W-1:0] IR_CAPTURE_SIG = 3'b001;

endpackage

// File: rtl/wcw_instr_reg.sv
module wcw_instr_reg
    import wcw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ser_in,
    input  logic      sel,
    input  logic      cap,
    input  logic      shf,
    input  logic      upd,
    output logic      lsb_out,
    output wcw_mode_e mode,
    output logic      wbr_sel
);

    logic [OP_W-1:0] stage_q;
    wcw_op_e         op_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (sel && shf) begin
            stage_q <= {ser_in, stage_q[OP_W-1:1]};
        end else if (sel && cap) begin
            stage_q <= IR_CAPTURE_SIG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_BYPASS;
        end else if (sel && upd) begin
            op_q <= wcw_op_e'(stage_q);
        end
    end

    assign lsb_out = stage_q[0];

    always_comb begin
        unique case (op_q)
            OP_EXTEST:  begin mode = MODE_OUTWARD; wbr_sel = 1'b1; end
            OP_PRELOAD: begin mode = MODE_NORMAL;  wbr_sel = 1'b1; end
            OP_INTEST:  begin mode = MODE_INWARD;  wbr_sel = 1'b1; end
            OP_CLAMP:   begin mode = MODE_OUTWARD; wbr_sel = 1'b0; end
            OP_SAFE:    begin mode = MODE_SAFE;    wbr_sel = 1'b0; end
            OP_BYPASS, OP_RSVD6, OP_RSVD7:
                        begin mode = MODE_NORMAL;  wbr_sel = 1'b0; end
        endcase
    end

    AST_OP_ONLY_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && upd) |=> $stable(op_q)); // R2

    AST_IR_CAPTURE_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cap && !shf) |=> (stage_q == IR_CAPTURE_SIG)); // R3

endmodule

// File: rtl/wcw_cell.sv
module wcw_cell
    import wcw_pkg::*;
#(
    parameter logic IS_CORE_IN = 1'b0,
    parameter logic SAFE_BIT   = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cti,
    input  logic      shf,
    input  logic      cap,
    input  logic      xfer,
    input  logic      upd,
    input  wcw_mode_e mode,
    input  logic      fi,
    output logic      fo,
    output logic      cto
);

    logic hold_q;
    logic sp_q;
    logic upd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            sp_q   <= 1'b0;
            upd_q  <= 1'b0;
        end else begin
            if (shf) begin
                sp_q <= cti;
            end else if (cap) begin
                hold_q <= fi;
            end else if (xfer) begin
                sp_q <= hold_q;
            end
            if (upd) begin
                upd_q <= sp_q;
            end
        end
    end

    assign cto = sp_q;

    always_comb begin
        unique case (mode)
            MODE_NORMAL:  fo = fi;
            MODE_INWARD:  fo = IS_CORE_IN ? upd_q : fi;
            MODE_OUTWARD: fo = IS_CORE_IN ? fi : upd_q;
            MODE_SAFE:    fo = SAFE_BIT;
        endcase
    end

    AST_SHIFT_BEATS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (shf && cap) |=> $stable(hold_q)); // R13

    AST_CAPTURE_BEATS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && xfer && !shf) |=> $stable(sp_q)); // R13

    AST_UPDATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(upd_q)); // R8

endmodule

// File: rtl/wcw_boundary.sv
module wcw_boundary
    import wcw_pkg::*;
#(
    parameter int                    NUM_CELLS    = 4,
    parameter logic [NUM_CELLS-1:0] CORE_IN_MASK = '0,
    parameter logic [NUM_CELLS-1:0] SAFE_VALUE   = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_in,
    input  logic                 shf,
    input  logic                 cap,
    input  logic                 xfer,
    input  logic                 upd,
    input  wcw_mode_e            mode,
    input  logic [NUM_CELLS-1:0] fi,
    output logic [NUM_CELLS-1:0] fo,
    output logic                 ser_out
);

    logic [NUM_CELLS-1:0] cto;

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        logic cti;
        if (i == NUM_CELLS - 1) begin : g_head
            assign cti = ser_in;
        end else begin : g_link
            assign cti = cto[i+1];
        end

        wcw_cell #(
            .IS_CORE_IN (CORE_IN_MASK[i]),
            .SAFE_BIT   (SAFE_VALUE[i])
        ) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .cti  (cti),
            .shf  (shf),
            .cap  (cap),
            .xfer (xfer),
            .upd  (upd),
            .mode (mode),
            .fi   (fi[i]),
            .fo   (fo[i]),
            .cto  (cto[i])
        );
    end

    assign ser_out = cto[0];

endmodule

// File: rtl/core_wrap_ctrl.sv
module core_wrap_ctrl
    import wcw_pkg::*;
#(
    parameter int                    NUM_CELLS    = 4,
    parameter logic [NUM_CELLS-1:0] CORE_IN_MASK = 4'b0011,
    parameter logic [NUM_CELLS-1:0] SAFE_VALUE   = 4'b0101
) (
    input  logic                 tclk,
    input  logic                 trst_n,
    input  logic                 ser_in,
    input  logic                 sel_instr,
    input  logic                 cap_en,
    input  logic                 shf_en,
    input  logic                 upd_en,
    input  logic                 xfer_en,
    input  logic [NUM_CELLS-1:0] func_in,
    output logic [NUM_CELLS-1:0] func_out,
    output logic                 ser_out
);

    wcw_mode_e mode;
    logic      wbr_sel;
    logic      ir_out;
    logic      wbr_out;
    logic      byp_q;
    logic      dr_path;
    logic      wbr_act;
    logic      byp_act;

    assign dr_path = !sel_instr;
    assign wbr_act = dr_path && wbr_sel;
    assign byp_act = dr_path && !wbr_sel;

    wcw_instr_reg u_ir (
        .clk    (tclk),
        .rst_n  (trst_n),
        .ser_in (ser_in),
        .sel    (sel_instr),
        .cap    (cap_en),
        .shf    (shf_en),
        .upd    (upd_en),
        .lsb_out(ir_out),
        .mode   (mode),
        .wbr_sel(wbr_sel)
    );

    wcw_boundary #(
        .NUM_CELLS   (NUM_CELLS),
        .CORE_IN_MASK(CORE_IN_MASK),
        .SAFE_VALUE  (SAFE_VALUE)
    ) u_wbr (
        .clk    (tclk),
        .rst_n  (trst_n),
        .ser_in (ser_in),
        .shf    (wbr_act && shf_en),
        .cap    (wbr_act && cap_en),
        .xfer   (wbr_act && xfer_en),
        .upd    (wbr_act && upd_en),
        .mode   (mode),
        .fi     (func_in),
        .fo     (func_out),
        .ser_out(wbr_out)
    );

    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (byp_act && shf_en) begin
            byp_q <= ser_in;
        end else if (byp_act && cap_en) begin
            byp_q <= 1'b0;
        end
    end

    always_comb begin
        if (sel_instr)    ser_out = ir_out;
        else if (wbr_sel) ser_out = wbr_out;
        else              ser_out = byp_q;
    end

    AST_BYPASS_DELAY: assert property (@(posedge tclk) disable iff (!trst_n)
        (byp_act && shf_en) |=> (byp_q == $past(ser_in))); // R4

    AST_SAFE_DRIVE: assert property (@(posedge tclk) disable iff (!trst_n)
        (mode == MODE_SAFE) |-> (func_out == SAFE_VALUE)); // R12

    AST_NORMAL_PASS: assert property (@(posedge tclk) disable iff (!trst_n)
        (mode == MODE_NORMAL) |-> (func_out == func_in)); // R9

endmodule

// File: tb/core_wrap_ctrl_test.sv
module core_wrap_ctrl_test;

    localparam int         CLK_PERIOD = 10;
    localparam int         N    = 4;
    localparam logic [3:0] MASK = 4'b0011;
    localparam logic [3:0] SAFE = 4'b0101;

    logic         tclk = 1'b0;
    logic         trst_n;
    logic         ser_in, sel_instr, cap_en, shf_en, upd_en, xfer_en;
    logic [N-1:0] func_in;
    logic [N-1:0] func_out;
    logic         ser_out;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD/2) tclk = ~tclk;

    core_wrap_ctrl #(.NUM_CELLS(N), .CORE_IN_MASK(MASK), .SAFE_VALUE(SAFE)) uut (
        .tclk(tclk), .trst_n(trst_n), .ser_in(ser_in), .sel_instr(sel_instr),
        .cap_en(cap_en), .shf_en(shf_en), .upd_en(upd_en), .xfer_en(xfer_en),
        .func_in(func_in), .func_out(func_out), .ser_out(ser_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic s, input logic c, input logic sh,
                       input logic u, input logic x, input logic si);
        sel_instr = s; cap_en = c; shf_en = sh; upd_en = u; xfer_en = x; ser_in = si;
        @(negedge tclk);
        sel_instr = 1'b0; cap_en = 1'b0; shf_en = 1'b0; upd_en = 1'b0; xfer_en = 1'b0;
    endtask

    task automatic load_op(input logic [2:0] code);
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, code[k]);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic wbr_shift(input logic [N-1:0] din, output logic [N-1:0] dout);
        for (int k = 0; k < N; k++) begin
            sel_instr = 1'b0; cap_en = 1'b0; upd_en = 1'b0; xfer_en = 1'b0;
            shf_en = 1'b1; ser_in = din[k];
            #1;
            dout[k] = ser_out;
            @(negedge tclk);
        end
        shf_en = 1'b0;
    endtask

    function automatic logic [N-1:0] exp_out(input logic [2:0] code,
                                             input logic [N-1:0] fi, input logic [N-1:0] u);
        case (code)
            3'b001, 3'b100: return (fi & MASK) | (u & ~MASK);
            3'b011:         return (u & MASK) | (fi & ~MASK);
            3'b101:         return SAFE;
            default:        return fi;
        endcase
    endfunction

    function automatic string mode_req(input logic [2:0] code);
        case (code)
            3'b001, 3'b100: return "R10 outward";
            3'b011:         return "R11 inward";
            3'b101:         return "R12 safe";
            default:        return "R9 normal";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge tclk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [N-1:0] o;
        logic [2:0]   ir_read;
        logic [7:0]   pat;
        trst_n = 1'b0; ser_in = 0; sel_instr = 0; cap_en = 0; shf_en = 0;
        upd_en = 0; xfer_en = 0; func_in = 4'b1010;
        repeat (2) @(negedge tclk);
        trst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 pass-through", func_out, 4'b1010);
        chk("R1 bypass bit", ser_out, 0);
        sel_instr = 1'b1; #1;
        chk("R1 instr stage", ser_out, 0);
        sel_instr = 1'b0;
        @(negedge tclk);

        // R3 instruction capture signature
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            sel_instr = 1'b1; shf_en = 1'b1; ser_in = 1'b0; #1;
            ir_read[k] = ser_out;
            @(negedge tclk);
        end
        shf_en = 1'b0; sel_instr = 1'b0;
        chk("R3 capture signature", ir_read, 3'b001);
        func_in = 4'b0110; #1;
        chk("R2 no update no mode change", func_out, 4'b0110);

        // R4 bypass one-cycle delay
        pat = 8'b1011_0010;
        for (int k = 0; k < 8; k++) begin
            sel_instr = 1'b0; shf_en = 1'b1; ser_in = pat[k]; #1;
            chk("R4 bypass delay", ser_out, (k == 0) ? 1'b0 : pat[k-1]);
            @(negedge tclk);
        end
        shf_en = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1); #1;
        chk("R4 bypass holds shifted 1", ser_out, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); #1;
        chk("R4 bypass capture zero", ser_out, 1'b0);

        // R5 preload a pattern into the update bits
        load_op(3'b010);
        wbr_shift(4'b1001, o);
        chk("R5 chain reset content", o, 4'b0000);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

        // R9-R12 sweep over every code and every input
        for (int c = 0; c < 8; c++) begin
            load_op(3'(c));
            for (int f = 0; f < 16; f++) begin
                func_in = 4'(f); #1;
                chk(mode_req(3'(c)), func_out, exp_out(3'(c), 4'(f), 4'b1001));
            end
            @(negedge tclk);
        end

        // R5 chain order
        load_op(3'b010);
        wbr_shift(4'b0110, o);
        chk("R5 old content out", o, 4'b1001);
        wbr_shift(4'b0000, o);
        chk("R5 new content out", o, 4'b0110);

        // R6 capture into hold, R7 transfer
        func_in = 4'b1101;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        func_in = 4'b0000;
        wbr_shift(4'b0000, o);
        chk("R6 capture leaves shift bits", o, 4'b0000);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        wbr_shift(4'b0000, o);
        chk("R7 transfer exposes capture", o, 4'b1101);

        // R8 update timing under outward mode (R10)
        load_op(3'b001);
        func_in = 4'b0000; #1;
        chk("R10 outward old update", func_out, 4'b1000);
        wbr_shift(4'b0110, o); #1;
        chk("R8 no change before update", func_out, 4'b1000);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); #1;
        chk("R8 new value after update", func_out, 4'b0100);

        // R13 shift beats capture
        func_in = 4'b0011;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        func_in = 4'b1100;
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        wbr_shift(4'b0000, o);
        chk("R13 shift beats capture", o, 4'b0011);
        // R13 capture beats transfer
        wbr_shift(4'b1010, o);
        func_in = 4'b0110;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        wbr_shift(4'b0000, o);
        chk("R13 capture beats transfer", o, 4'b1010);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        wbr_shift(4'b0000, o);
        chk("R13 capture took effect", o, 4'b0110);

        // R14 cells untouched while bypass selected (clamp)
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // update bits <- 0000
        func_in = 4'b0110;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // hold <- 0110
        load_op(3'b100);
        func_in = 4'b0000; #1;
        chk("R10 clamp outward", func_out, 4'b0000);
        func_in = 4'b1111;
        wbr_shift(4'b1111, o);
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        func_in = 4'b0000; #1;
        chk("R14 update ignored", func_out, 4'b0000);
        load_op(3'b001);
        wbr_shift(4'b0000, o);
        chk("R14 shift ignored", o, 4'b0000);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        wbr_shift(4'b0000, o);
        chk("R14 capture ignored", o, 4'b0110);

        // R2 update with sel_instr low does not load an instruction
        for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, SAFE_CODE_BIT(k));
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        func_in = 4'b0000; #1;
        chk("R2 update needs sel_instr", func_out, 4'b0000);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); #1;
        chk("R2 instruction takes effect", func_out, SAFE);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    function automatic logic SAFE_CODE_BIT(input int k);
        logic [2:0] code = 3'b101;
        return code[k];
    endfunction

endmodule